// File: doc/BRIEF.md
# Single-Port RAM Delay Line Sequencer

This block turns an external single-port RAM into a fixed-length synchronous delay line. Each RAM word holds two samples. A phase counter runs through `CNT_MAX + 1` steps. Its least significant bit picks the phase, and its upper bits give the word address.

The phase has two states, both of type `phase_t`:

- `PH_FILL` (counter even). The incoming sample is captured into a holding register, and the word at the current address is read.
- `PH_COMMIT` (counter odd). The held sample and the current sample are packed into one word. That word is written back to the same address.

While enabled, each step moves the phase `PH_FILL` -> `PH_COMMIT` or `PH_COMMIT` -> `PH_FILL`. The step from `PH_COMMIT` at the top count wraps to address zero. When enable is low, the phase and the address hold.

The RAM is outside the block. The block drives its address, write enable and write data, and takes its read data back one cycle after the address. Two cycles after a `PH_FILL` step, a select pulse appears. On that pulse the upper half of the returned word goes to the output sample register. The lower half follows on the next cycle. With enable held high, every sample reappears at the output `CNT_MAX + 4` cycles after it entered.

Top module: `sp_delay_ctrl`

## Requirements
- R1: While reset is high, the next clock edge sets `ram_addr`, `ram_we`, `sel`, `ram_wdata` and `dout` to zero, and the phase counter restarts at zero.
- R2: `ram_addr` in a cycle equals the phase counter of the previous cycle shifted right by one. The counter's bit 0 selects the phase: 0 is `PH_FILL`, 1 is `PH_COMMIT`.
- R3: `ram_we` is high in a cycle exactly when the previous cycle was `PH_COMMIT` with `en` high. It is never high in two consecutive cycles.
- R4: `sel` is high in a cycle exactly when the cycle two earlier was `PH_FILL` with `en` high. It is never high in two consecutive cycles.
- R5: With `en` high, the counter steps by one and wraps from `CNT_MAX` to zero. `CNT_MAX` is odd.
- R6: When `ram_we` is high after two enabled cycles, `ram_wdata` holds the sample from the `PH_FILL` cycle in bits [2*DW-1:DW] and the sample from the `PH_COMMIT` cycle in bits [DW-1:0].
- R7: With `en` held high since reset, `dout` equals `din` from `CNT_MAX + 4` cycles earlier.
- R8: While `en` is low, the counter and `ram_addr` hold, and `ram_we` stays low, so no RAM word changes.
- R9: The cycle after `sel`, `dout` shows the upper half of the `ram_rdata` present with `sel`. The cycle after that, `dout` shows the lower half of the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable; when low, the sequence freezes |
| din | input | DW | Incoming sample |
| ram_rdata | input | 2*DW | Word read from the RAM, one cycle after its address |
| ram_addr | output | CW-1 | RAM word address |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 2*DW | Packed two-sample word for the RAM |
| sel | output | 1 | Marks the cycle in which `ram_rdata` carries a word to unpack |
| dout | output | DW | Delayed sample |

## Verification
`ram_addr` and `ram_we` are due one cycle after the counter state that causes them. `sel` is due two cycles after its cause, and `ram_wdata` is valid together with `ram_we`. The upper half of a read word reaches `dout` one cycle after `sel`, and the lower half two cycles after `sel`. From end to end, a sample reaches `dout` `CNT_MAX + 4` cycles after it entered.

The bench keeps a per-cycle history of its inputs and of a behavioural counter. It samples every output on the falling edge and compares each one against the history entry that is the stated number of cycles back. The delay check only runs once a full period of enabled cycles has passed since reset, with no stall in between.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
    typedef enum logic {
        PH_FILL   = 1'b0,
        PH_COMMIT = 1'b1
    } phase_t;
endpackage

// File: rtl/sdl_ctrl.sv
module sdl_ctrl
    import sdl_pkg::*;
#(
    parameter int CW      = 9,
    parameter int CNT_MAX = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output phase_t        phase,
    output logic [CW-1:0] count_o,
    output logic [CW-2:0] addr_o,
    output logic          we_o,
    output logic          sel_o
);
    localparam logic [CW-1:0] WRAP = CW'(CNT_MAX);

    logic [CW-1:0] cnt_q;
    logic          sel_a_q;

    assign phase   = phase_t'(cnt_q[0]);
    assign count_o = cnt_q;

    // phase counter: state register
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en) begin
            if (cnt_q == WRAP) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // control outputs, staggered pipeline
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o  <= '0;
            we_o    <= 1'b0;
            sel_a_q <= 1'b0;
            sel_o   <= 1'b0;
        end else begin
            addr_o  <= cnt_q[CW-1:1];
            we_o    <= 1'b0;
            sel_a_q <= 1'b0;
            unique case (phase)
                PH_FILL:   sel_a_q <= en;
                PH_COMMIT: we_o    <= en;
            endcase
            sel_o <= sel_a_q;
        end
    end
endmodule

// File: rtl/sdl_pack.sv
module sdl_pack
    import sdl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  phase_t          phase,
    input  logic [DW-1:0]   din,
    output logic [2*DW-1:0] wdata_o
);
    logic [DW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            wdata_o <= '0;
        end else if (en) begin
            unique case (phase)
                PH_FILL:   hold_q  <= din;
                PH_COMMIT: wdata_o <= {hold_q, din};
            endcase
        end
    end
endmodule

// File: rtl/sdl_unpack.sv
module sdl_unpack #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel,
    input  logic [2*DW-1:0] rdata,
    output logic [DW-1:0]   dout_o
);
    logic          sel_d_q;
    logic [DW-1:0] low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_d_q <= 1'b0;
            low_q   <= '0;
            dout_o  <= '0;
        end else begin
            sel_d_q <= sel;
            if (sel) begin
                dout_o <= rdata[2*DW-1:DW];
                low_q  <= rdata[DW-1:0];
            end else if (sel_d_q) begin
                dout_o <= low_q;
            end
        end
    end
endmodule

// File: rtl/sp_delay_ctrl.sv
module sp_delay_ctrl
    import sdl_pkg::*;
#(
    parameter int DW      = 8,
    parameter int CW      = 9,
    parameter int CNT_MAX = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [DW-1:0]   din,
    input  logic [2*DW-1:0] ram_rdata,
    output logic [CW-2:0]   ram_addr,
    output logic            ram_we,
    output logic [2*DW-1:0] ram_wdata,
    output logic            sel,
    output logic [DW-1:0]   dout
);
    phase_t        phase;
    logic [CW-1:0] cnt_w;

    sdl_ctrl #(.CW(CW), .CNT_MAX(CNT_MAX)) u_ctrl (
        .clk(clk), .rst(rst), .en(en), .phase(phase), .count_o(cnt_w),
        .addr_o(ram_addr), .we_o(ram_we), .sel_o(sel)
    );

    sdl_pack #(.DW(DW)) u_pack (
        .clk(clk), .rst(rst), .en(en), .phase(phase), .din(din),
        .wdata_o(ram_wdata)
    );

    sdl_unpack #(.DW(DW)) u_unpack (
        .clk(clk), .rst(rst), .sel(sel), .rdata(ram_rdata), .dout_o(dout)
    );
endmodule

// File: rtl/sdl_chk.sv
module sdl_chk #(
    parameter int CW      = 9,
    parameter int CNT_MAX = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic [CW-1:0] cnt,
    input logic          ram_we,
    input logic          sel
);
    // R3
    we_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt[0]) |=> ram_we);

    // R3
    we_no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> !ram_we);

    // R4
    sel_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !cnt[0]) |=> ##1 sel);

    // R4
    sel_no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        sel |=> !sel);

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == CW'(CNT_MAX)) |=> (cnt == '0));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));
endmodule

bind sp_delay_ctrl sdl_chk #(.CW(CW), .CNT_MAX(CNT_MAX)) u_sdl_chk (
    .clk(clk), .rst(rst), .en(en), .cnt(cnt_w), .ram_we(ram_we), .sel(sel)
);

// File: tb/test_sp_delay_ctrl.sv
module test_sp_delay_ctrl;
    localparam int DW = 8;
    localparam int CW = 9;
    localparam int CMAX = 5;
    localparam int AW = CW - 1;
    localparam int DLY = CMAX + 4;
    localparam int N = 2048;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst = 1'b1;
    logic            en = 1'b0;
    logic [DW-1:0]   din = '0;
    logic [2*DW-1:0] ram_rdata = '0;
    logic [AW-1:0]   ram_addr;
    logic            ram_we;
    logic [2*DW-1:0] ram_wdata;
    logic            sel;
    logic [DW-1:0]   dout;

    sp_delay_ctrl #(.DW(DW), .CW(CW), .CNT_MAX(CMAX)) i_sp_delay_ctrl (
        .clk(clk), .rst(rst), .en(en), .din(din), .ram_rdata(ram_rdata),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .sel(sel), .dout(dout)
    );

    // behavioural single-port RAM, read-before-write
    logic [2*DW-1:0] mem [0:(1<<AW)-1];
    initial for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    always @(posedge clk) begin
        ram_rdata <= mem[ram_addr];
        if (ram_we) mem[ram_addr] <= ram_wdata;
    end

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int run_start = 0;
    int h_cnt [N];
    int h_en  [N];
    int h_rst [N];
    int h_din [N];
    int h_s1  [N];
    int h_sel [N];
    int h_rd  [N];

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    task automatic step(input logic e, input logic [DW-1:0] d, input logic r);
        rst = r; en = e; din = d;
        h_rst[cyc] = int'(r); h_en[cyc] = int'(e); h_din[cyc] = int'(d);
        @(posedge clk);
        cyc++;
        @(negedge clk);
        // reference counter
        if (h_rst[cyc-1] != 0) h_cnt[cyc] = 0;
        else if (h_en[cyc-1] != 0) h_cnt[cyc] = (h_cnt[cyc-1] == CMAX) ? 0 : h_cnt[cyc-1] + 1;
        else h_cnt[cyc] = h_cnt[cyc-1];
        h_s1[cyc] = (h_rst[cyc-1] == 0 && h_cnt[cyc-1] % 2 == 0 && h_en[cyc-1] != 0) ? 1 : 0;
        h_sel[cyc] = int'(sel);
        h_rd[cyc] = int'(ram_rdata);
        if (h_rst[cyc-1] != 0) begin
            run_start = cyc;
            chk("R1 addr", int'(ram_addr), 0);
            chk("R1 we", int'(ram_we), 0);
            chk("R1 sel", int'(sel), 0);
            chk("R1 wdata", int'(ram_wdata), 0);
            chk("R1 dout", int'(dout), 0);
        end else begin
            if (h_en[cyc-1] == 0) run_start = N;
            chk("R2 addr", int'(ram_addr), h_cnt[cyc-1] / 2);
            chk("R3 we", int'(ram_we), (h_cnt[cyc-1] % 2 == 1 && h_en[cyc-1] != 0) ? 1 : 0);
            chk("R4 sel", int'(sel), h_s1[cyc-1]);
            if (h_en[cyc-1] == 0)
                chk("R8 no write while stalled", int'(ram_we), 0);
            if (ram_we && h_en[cyc-2] != 0 && h_rst[cyc-2] == 0)
                chk("R6 wdata", int'(ram_wdata), (h_din[cyc-2] << DW) | h_din[cyc-1]);
            if (cyc >= 2 && h_rst[cyc-2] == 0 && h_sel[cyc-1] != 0)
                chk("R9 upper half", int'(dout), h_rd[cyc-1] >> DW);
            if (cyc >= 3 && h_rst[cyc-2] == 0 && h_rst[cyc-3] == 0 && h_sel[cyc-2] != 0)
                chk("R9 lower half", int'(dout), h_rd[cyc-2] & ((1 << DW) - 1));
            if (cyc - DLY >= run_start && run_start < N)
                chk("R7 delay", int'(dout), h_din[cyc-DLY]);
        end
        chk("R5 wrap bound", (h_cnt[cyc] <= CMAX) ? 1 : 0, 1);
    endtask

    logic done = 1'b0;

    initial begin
        h_cnt[0] = 0; h_s1[0] = 0; h_sel[0] = 0; h_rd[0] = 0;
        h_rst[0] = 1; h_en[0] = 0; h_din[0] = 0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b1, '0, 1'b1);
        // R7: ramp pattern
        for (int i = 0; i < 60; i++) step(1'b1, DW'(i + 1), 1'b0);
        // R7: random pattern
        for (int i = 0; i < 80; i++) step(1'b1, DW'($urandom), 1'b0);
        // R8: stall with a pattern on din that must not be written
        for (int i = 0; i < 7; i++) step(1'b0, DW'(8'hA5 ^ i), 1'b0);
        for (int i = 0; i < 20; i++) step(1'b1, DW'($urandom), 1'b0);
        // R8: single-cycle gaps
        for (int i = 0; i < 40; i++) step(i % 3 != 0, DW'(i * 7), 1'b0);
        // R1: reset mid-stream, then alternating pattern
        for (int i = 0; i < 2; i++) step(1'b1, 8'hFF, 1'b1);
        for (int i = 0; i < 60; i++) step(1'b1, (i % 2 == 0) ? 8'h55 : 8'hAA, 1'b0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule